// File: doc/BRIEF.md
# Ripple Modulo-3 Counter with Retimed Outputs

This block counts system clock cycles modulo three with a chain of toggle flip-flops in which only the lowest stage sees the system clock. Each higher stage takes its clock from the stage below it, so a carry ripples from stage to stage instead of being computed in logic. The chain is wrapped by decoding the terminal value, which is all ones for the default modulus. That decode drives the asynchronous clear of every stage, so the chain passes through the terminal value for a moment and falls back to zero within the same clock cycle.

A bank of output flip-flops on the system clock samples the chain. The brief terminal value has been cleared long before the next rising edge, so downstream logic only ever sees 0, 1, 2, 0, ... with one cycle of latency. An external active-low reset clears the chain at once, whether or not the clock is running. It also clears the output bank at the next rising clock edge. The modulus is a parameter, and the chain width follows from it.

Top module: `ripple_mod3_counter`

## Requirements
- R1: While `rst_n` is low, every rising edge of `clk` loads 0 into `cnt_o`.
- R2: With `rst_n` high, `cnt_o` advances by one on every rising edge of `clk` in the order 0, 1, 2, 0.
- R3: `cnt_o` never holds the value 3 at any rising clock edge, including just after the wrap.
- R4: `cnt_o` trails the internal chain by one cycle. After reset is released between two edges, the first rising edge shows 0 and the second shows 1.
- R5: A low pulse on `rst_n` that lies entirely between two rising edges clears the chain at once but leaves `cnt_o` unchanged. The next rising edge then shows 0.
- R6: When the chain reaches all ones, it is cleared within the same clock cycle. The clear is released before the next rising edge, so after `cnt_o` shows 2 the sequence continues 0, 1 with no lost or extra step.
- R7: Releasing `rst_n` between edges changes nothing until the next rising edge of `clk`. Until that edge, `cnt_o` keeps the value it held before the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rising edge advances the lowest stage and loads the output bank |
| rst_n | input | 1 | Active-low reset; asynchronous clear of the chain, synchronous clear of the output bank |
| cnt_o | output | 2 | Registered count, 0 to 2 |

## Verification
Two functions can fall in the same cycle: the wrap clear raised by the decode and an external reset. They can arrive together as a rising edge that lands on the terminal value while `rst_n` is low, or as a short reset pulse inside a cycle whose chain has just wrapped. The bench provokes both with forced and pseudo-random reset pulses, some spanning whole cycles and some lying entirely between edges. A behavioural model of the count predicts `cnt_o` after every rising edge. It judges each cycle by whether the sequence restarts from 0 exactly where the model says and by whether the value 3 ever appears.

// File: rtl/ripple_cnt_pkg.sv
// Package: ripple_cnt_pkg
// Shared constants and helpers for the ripple modulo counter.
// Assumes: the modulus is at least 2.
package ripple_cnt_pkg;

    // Default modulus of the counter
    localparam int DEFAULT_MOD = 3;

    // Number of chain stages needed to hold the terminal value itself
    function automatic int chain_width(input int modulus);
        return $clog2(modulus + 1);
    endfunction

endpackage

// File: rtl/ripple_tbit.sv
// Module: ripple_tbit
// One toggle stage of the ripple chain. The output inverts on every rising
// edge of tick_i. A low level on clr_ni forces the output to 0 at once and
// holds it there, whatever tick_i does.
// Assumes: clr_ni is released away from rising edges of tick_i.
module ripple_tbit (
    input  logic tick_i,
    input  logic clr_ni,
    output logic q_o
);

    // Toggle on each local clock edge, asynchronous clear dominates
    always_ff @(posedge tick_i or negedge clr_ni) begin
        if (!clr_ni) begin
            q_o <= 1'b0;
        end else begin
            q_o <= ~q_o;
        end
    end

endmodule

// File: rtl/ripple_wrap_decode.sv
// Module: ripple_wrap_decode
// Detects the terminal value on the chain and produces the active-low
// asynchronous clear for all stages. The clear is the AND of the external
// reset, the inverted terminal decode and the inverted hold flag. The hold
// flag is set the moment the decode fires and is dropped on the next falling
// edge of clk. This keeps the clear asserted while the falling lower bits
// ripple into the higher stages, and releases it half a cycle before the next
// rising edge.
// Assumes: decode plus clear propagation fits in half a clock period.
module ripple_wrap_decode #(
    parameter int CW  = 2,
    parameter int MOD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    output logic          clr_no
);

    localparam logic [CW-1:0] TERM = CW'(MOD);

    logic wrap_hit;
    logic wrap_hold;

    // Terminal decode: every bit that is one in the modulus is set
    assign wrap_hit = &(cnt_i | ~TERM);

    // Hold flag: set by the decode, released on the falling clock edge
    always_ff @(negedge clk or posedge wrap_hit) begin
        if (wrap_hit) begin
            wrap_hold <= 1'b1;
        end else begin
            wrap_hold <= 1'b0;
        end
    end

    // Combined active-low clear for the whole chain
    assign clr_no = rst_n & ~wrap_hit & ~wrap_hold;

    AST_NO_TERM_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_i != TERM) else $error("chain holds terminal value at rising edge"); // R6

    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_hold) else $error("wrap clear still held at rising edge"); // R6

endmodule

// File: rtl/ripple_out_reg.sv
// Module: ripple_out_reg
// Retiming bank on the system clock. It samples the ripple chain at each
// rising edge, so transient chain values never reach the output. A low
// rst_n at a rising edge loads zero.
// Assumes: the chain has settled well before each rising edge.
module ripple_out_reg #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] d_i,
    output logic [CW-1:0] q_o
);

    // Sample the chain, synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

    AST_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> q_o == '0) else $error("output not cleared by reset"); // R1

endmodule

// File: rtl/ripple_mod3_counter.sv
// Module: ripple_mod3_counter
// Ripple counter wrapped at MOD through an asynchronous clear, with a
// registered output. Stage 0 toggles on the rising clk edge. Stage i (i > 0)
// toggles when stage i-1 falls, using its inverted output as the clock.
// Assumes: rst_n release is kept away from rising clk edges by the caller.
module ripple_mod3_counter
    import ripple_cnt_pkg::*;
#(
    parameter int MOD = DEFAULT_MOD
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [chain_width(MOD)-1:0] cnt_o
);

    localparam int CW = chain_width(MOD);

    logic [CW-1:0] chain_q;
    logic [CW-1:0] stage_tick;
    logic          chain_clr_n;

    // Local clocks: the system clock for stage 0, falling edge of the stage below otherwise
    generate
        for (genvar gi = 0; gi < CW; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                assign stage_tick[gi] = clk;
            end else begin : g_rest
                assign stage_tick[gi] = ~chain_q[gi-1];
            end

            ripple_tbit u_tbit (
                .tick_i (stage_tick[gi]),
                .clr_ni (chain_clr_n),
                .q_o    (chain_q[gi])
            );
        end
    endgenerate

    ripple_wrap_decode #(
        .CW  (CW),
        .MOD (MOD)
    ) u_wrap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (chain_q),
        .clr_no (chain_clr_n)
    );

    ripple_out_reg #(
        .CW (CW)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (chain_q),
        .q_o   (cnt_o)
    );

    AST_NO_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o < CW'(MOD)) else $error("terminal value reached the output"); // R3

endmodule

// File: tb/test_ripple_mod3_counter.sv
`timescale 1ns/1ps
// Bench for ripple_mod3_counter: a behavioural modulo-3 model checked after every rising edge.
module test_ripple_mod3_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [1:0] cnt_o;

    int checks = 0;
    int fails = 0;
    int cnt_m = 0;      // model of the internal chain
    int out_m = 0;      // model of the output bank
    int prev_m = 0;
    int since_rel = 0;
    bit rst_cur = 1'b0;
    int unsigned lfsr = 32'h1234_5678;

    ripple_mod3_counter i_ripple_mod3_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt_o)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_not3();
        checks++;
        if (cnt_o === 2'd3 || $isunknown(cnt_o)) begin
            fails++;
            $display("FAIL R3: actual=%0d expected=0..2 at %0t", cnt_o, $time);
        end
    endtask

    // Called at a falling edge: apply reset level r, run one rising edge, check
    task automatic run_cycle(input bit r);
        string tag;
        if (!r) begin
            rst_n = 1'b0;
            cnt_m = 0;
        end else if (!rst_n) begin
            rst_n = 1'b1;
            #0.3;
            chk("R7", cnt_o, 2'(out_m));   // release alone changes nothing
        end
        rst_cur = r;
        @(posedge clk);
        prev_m = out_m;
        if (!rst_cur) begin
            out_m = 0;
            cnt_m = 0;
            since_rel = 0;
        end else begin
            out_m = cnt_m;
            cnt_m = (cnt_m + 1) % 3;
        end
        @(negedge clk);
        if (!rst_cur)            tag = "R1";
        else if (since_rel < 2)  tag = "R4";
        else if (prev_m == 2)    tag = "R6";
        else                     tag = "R2";
        chk(tag, cnt_o, 2'(out_m));
        chk_not3();
        if (rst_cur) since_rel++;
    endtask

    // Short reset pulse lying between a falling and the next rising edge
    task automatic short_pulse();
        #0.5 rst_n = 1'b0;
        cnt_m = 0;
        #0.5;
        chk("R5", cnt_o, 2'(out_m));     // output bank untouched by the pulse
        rst_n = 1'b1;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL R2: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #0.5 rst_n = 1'b0;
        @(negedge clk);
        chk("R1", cnt_o, 2'd0);
        run_cycle(1'b0);
        run_cycle(1'b0);
        for (int i = 0; i < 90; i++) begin
            bit r;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            r = 1'b1;
            if (i == 20 || i == 21 || i == 50) r = 1'b0;
            else if (i > 30 && (lfsr % 11) == 0) r = 1'b0;
            if (r && (i == 9 || i == 40 || i == 71 || (i > 60 && (lfsr % 13) == 1)))
                short_pulse();
            run_cycle(r);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule